// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block collects a bank of level-sensitive interrupt lines and presents them to a primary interrupt controller in two ways. First, every line is gated by an enable mask. The gated lines are ORed into one summary request, which drives a fixed line of the parent vector. Second, a fixed window of lines (21 through 30 by default) can be routed one-for-one to the matching parent lines, so that sources with their own primary slot bypass the summary.

Software controls the block through a 32-bit register window of 4 KB. It uses a read strobe, a write strobe and a word index, which is the byte offset divided by four. The enable mask and the routing-enable set are each changed through a set/clear pair. A separate pair of indices sets or clears only mask bit 0, which acts as the software-interrupt enable. Every input is sampled on each clock, and the parent vector is registered. The parent vector therefore reflects the inputs and the register state one cycle after they change. Read data is returned one cycle after the read strobe.

Top module: `sirq_hub`

## Requirements
- R1: A synchronous active-high reset clears the sampled levels, the enable mask, the routing-enable set, `rdata` and `parent_irq`.
- R2: A read of index 1 returns the input levels sampled at the previous clock edge, one bit per line.
- R3: `parent_irq[31]` is 1 exactly when (sampled levels AND enable mask) is nonzero. It follows an input change one clock later.
- R4: A write to index 2 ORs `wdata` into the enable mask. A write to index 3 clears every mask bit set in `wdata`. A read of index 2 returns the mask.
- R5: Any nonzero write to index 4 sets mask bit 0, and any nonzero write to index 5 clears mask bit 0. A zero write to either index changes nothing.
- R6: A read of index 0 returns levels AND mask. A read of index 4 returns level bit 0 in bit 0, with zeros above it.
- R7: A write to index 8 ORs (`wdata` AND 0x7FE00000) into the routing-enable set, so only bits 21 to 30 can be set. A read of index 8 returns the set.
- R8: A write to index 9 clears every routing-enable bit that is set in `wdata`.
- R9: For i in 21..30, `parent_irq[i]` equals routing-enable bit i AND level bit i. A disabled line drives 0, and `parent_irq[20:0]` are always 0.
- R10: A read of any index other than 0, 1, 2, 4 and 8 returns 0. A write to any index other than 2, 3, 4, 5, 8 and 9 changes no state.
- R11: `rdata` is loaded at the clock edge that samples `rd_en`. When a read and a write hit the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 10 | Word index into the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| parent_irq | output | 32 | Bit 31 carries the summary request, bits 21..30 the routed lines, all other bits 0 |

## Verification
The assertions assume that `irq_in`, `addr`, `wdata` and the strobes settle before each rising edge and are free of X after reset. They also assume that `wr_en` and `rd_en` are plain single-cycle qualifiers, with no handshake. The stimulus meets these assumptions by changing every input on the falling edge only and by holding reset across the first edges. It also pulses each strobe for exactly one cycle. It writes to unused indices and makes zero writes to the soft-enable pair, so the assertions about unchanged state are exercised.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  // Word indices into the register window
  localparam int unsigned IX_MASKED   = 0;
  localparam int unsigned IX_RAW      = 1;
  localparam int unsigned IX_EN_SET   = 2;
  localparam int unsigned IX_EN_CLR   = 3;
  localparam int unsigned IX_SOFT_SET = 4;
  localparam int unsigned IX_SOFT_CLR = 5;
  localparam int unsigned IX_RT_SET   = 8;
  localparam int unsigned IX_RT_CLR   = 9;
endpackage

// File: rtl/sirq_capture.sv
module sirq_capture #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic [NUM_SRC-1:0] lvl_q
);
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= irq_in;
  end
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
  import sirq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned RT_LO   = 21,
  parameter int unsigned RT_HI   = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] lvl_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mask_d,
  output logic [NUM_SRC-1:0] rt_q,
  output logic [NUM_SRC-1:0] rt_d,
  output logic [NUM_SRC-1:0] rdata
);
  function automatic logic [NUM_SRC-1:0] window(input int unsigned lo, input int unsigned hi);
    logic [NUM_SRC-1:0] m;
    for (int unsigned i = 0; i < NUM_SRC; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction

  localparam logic [NUM_SRC-1:0] RT_WIN = window(RT_LO, RT_HI);

  logic wr_nz;
  logic [NUM_SRC-1:0] rd_val;
  assign wr_nz = |wdata;

  always_comb begin
    mask_d = mask_q;
    rt_d   = rt_q;
    if (wr_en) begin
      case (addr)
        ADDR_W'(IX_EN_SET):   mask_d = mask_q | wdata;
        ADDR_W'(IX_EN_CLR):   mask_d = mask_q & ~wdata;
        ADDR_W'(IX_SOFT_SET): if (wr_nz) mask_d[0] = 1'b1;
        ADDR_W'(IX_SOFT_CLR): if (wr_nz) mask_d[0] = 1'b0;
        ADDR_W'(IX_RT_SET):   rt_d = rt_q | (wdata & RT_WIN);
        ADDR_W'(IX_RT_CLR):   rt_d = rt_q & ~wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(IX_MASKED):   rd_val = lvl_q & mask_q;
      ADDR_W'(IX_RAW):      rd_val = lvl_q;
      ADDR_W'(IX_EN_SET):   rd_val = mask_q;
      ADDR_W'(IX_SOFT_SET): rd_val = {{(NUM_SRC-1){1'b0}}, lvl_q[0]};
      ADDR_W'(IX_RT_SET):   rd_val = rt_q;
      default:              rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      rt_q   <= '0;
      rdata  <= '0;
    end else begin
      mask_q <= mask_d;
      rt_q   <= rt_d;
      if (rd_en) rdata <= rd_val;
    end
  end

  // R7
  rt_window_chk: assert property (@(posedge clk) disable iff (rst)
    (rt_q & ~RT_WIN) == '0);

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(IX_EN_SET)) |=> ((mask_q & $past(wdata)) == $past(wdata)));

  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(IX_EN_CLR)) |=> ((mask_q & $past(wdata)) == '0));

  // R5
  soft_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata == '0 && (addr == ADDR_W'(IX_SOFT_SET) || addr == ADDR_W'(IX_SOFT_CLR)))
    |=> $stable(mask_q));

  // R8
  rt_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(IX_RT_CLR)) |=> ((rt_q & $past(wdata)) == '0));

  // R10
  unused_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(addr inside {ADDR_W'(IX_EN_SET), ADDR_W'(IX_EN_CLR), ADDR_W'(IX_SOFT_SET),
                             ADDR_W'(IX_SOFT_CLR), ADDR_W'(IX_RT_SET), ADDR_W'(IX_RT_CLR)}))
    |=> ($stable(mask_q) && $stable(rt_q)));
endmodule

// File: rtl/sirq_route.sv
module sirq_route #(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned PARENT_LINE = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] lvl_d,
  input  logic [NUM_SRC-1:0] mask_d,
  input  logic [NUM_SRC-1:0] rt_d,
  output logic [NUM_SRC-1:0] parent_irq
);
  logic [NUM_SRC-1:0] next_out;
  logic               summary;

  assign summary = |(lvl_d & mask_d);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
    if (i == PARENT_LINE) begin : g_sum
      // routing bits never reach this line, the OR only keeps every bit in use
      assign next_out[i] = summary | (rt_d[i] & lvl_d[i]);
    end else begin : g_direct
      assign next_out[i] = rt_d[i] & lvl_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) parent_irq <= '0;
    else     parent_irq <= next_out;
  end
endmodule

// File: rtl/sirq_hub.sv
module sirq_hub #(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned RT_LO       = 21,
  parameter int unsigned RT_HI       = 30,
  parameter int unsigned PARENT_LINE = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic [NUM_SRC-1:0] parent_irq
);
  logic [NUM_SRC-1:0] lvl_q, mask_q, mask_d, rt_q, rt_d;

  sirq_capture #(.NUM_SRC(NUM_SRC)) u_capture (
    .clk(clk), .rst(rst), .irq_in(irq_in), .lvl_q(lvl_q)
  );

  sirq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .RT_LO(RT_LO), .RT_HI(RT_HI)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .lvl_q(lvl_q), .mask_q(mask_q), .mask_d(mask_d), .rt_q(rt_q), .rt_d(rt_d), .rdata(rdata)
  );

  sirq_route #(.NUM_SRC(NUM_SRC), .PARENT_LINE(PARENT_LINE)) u_route (
    .clk(clk), .rst(rst), .lvl_d(irq_in), .mask_d(mask_d), .rt_d(rt_d), .parent_irq(parent_irq)
  );

  // R3
  summary_chk: assert property (@(posedge clk) disable iff (rst)
    parent_irq[PARENT_LINE] == (|(lvl_q & mask_q)));

  // R9
  routed_chk: assert property (@(posedge clk) disable iff (rst)
    (parent_irq & ~(NUM_SRC'(1) << PARENT_LINE)) == (rt_q & lvl_q));
endmodule

// File: tb/sirq_hub_tb.sv
module sirq_hub_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IRQ = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [9:0]  ix;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{OP_RD,  10'd2,    32'h0,         32'h0,         8'd1},  // R1 mask clear
    '{OP_IRQ, 10'd0,    32'h0000_0011, 32'h0,         8'd3},  // R3 nothing enabled
    '{OP_RD,  10'd1,    32'h0,         32'h0000_0011, 8'd2},  // R2 raw
    '{OP_WR,  10'd2,    32'h0000_0010, 32'h0,         8'd4},
    '{OP_RD,  10'd2,    32'h0,         32'h0000_0010, 8'd4},  // R4 set
    '{OP_RD,  10'd0,    32'h0,         32'h0000_0010, 8'd6},  // R6 masked
    '{OP_IRQ, 10'd0,    32'h0000_0011, 32'h8000_0000, 8'd3},  // R3 summary on
    '{OP_WR,  10'd4,    32'h0,         32'h0,         8'd5},  // R5 zero write
    '{OP_RD,  10'd2,    32'h0,         32'h0000_0010, 8'd5},
    '{OP_WR,  10'd4,    32'h0000_0005, 32'h0,         8'd5},
    '{OP_RD,  10'd2,    32'h0,         32'h0000_0011, 8'd5},  // R5 soft set
    '{OP_RD,  10'd4,    32'h0,         32'h0000_0001, 8'd6},  // R6 soft read
    '{OP_WR,  10'd5,    32'h0000_0080, 32'h0,         8'd5},
    '{OP_RD,  10'd2,    32'h0,         32'h0000_0010, 8'd5},  // R5 soft clear
    '{OP_WR,  10'd3,    32'h0000_0010, 32'h0,         8'd4},
    '{OP_IRQ, 10'd0,    32'h0000_0011, 32'h0,         8'd4},  // R4 clear drops summary
    '{OP_WR,  10'd8,    32'hFFFF_FFFF, 32'h0,         8'd7},
    '{OP_RD,  10'd8,    32'h0,         32'h7FE0_0000, 8'd7},  // R7 window only
    '{OP_IRQ, 10'd0,    32'hFFFF_FFFF, 32'h7FE0_0000, 8'd9},  // R9 routed
    '{OP_WR,  10'd9,    32'h0060_0000, 32'h0,         8'd8},
    '{OP_RD,  10'd8,    32'h0,         32'h7F80_0000, 8'd8},  // R8 clear
    '{OP_IRQ, 10'd0,    32'hFFFF_FFFF, 32'h7F80_0000, 8'd9},  // R9 disabled lines 0
    '{OP_WR,  10'd7,    32'hFFFF_FFFF, 32'h0,         8'd10},
    '{OP_WR,  10'd10,   32'hFFFF_FFFF, 32'h0,         8'd10},
    '{OP_RD,  10'd2,    32'h0,         32'h0,         8'd10}, // R10 mask untouched
    '{OP_RD,  10'd8,    32'h0,         32'h7F80_0000, 8'd10}, // R10 routing untouched
    '{OP_RD,  10'd6,    32'h0,         32'h0,         8'd10},
    '{OP_RD,  10'd1023, 32'h0,         32'h0,         8'd10},
    '{OP_WR,  10'd2,    32'h8000_0000, 32'h0,         8'd3},
    '{OP_IRQ, 10'd0,    32'h8000_0000, 32'h8000_0000, 8'd3},  // R3 top bit only
    '{OP_RD,  10'd0,    32'h0,         32'h8000_0000, 8'd6},
    '{OP_IRQ, 10'd0,    32'h4000_0001, 32'h4000_0000, 8'd9}   // R9 line 30 routed
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, parent_irq;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sirq_hub u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .parent_irq(parent_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic do_irq(input logic [31:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    // R1 outputs clear under reset
    check("R1 rdata in reset", rdata, 32'h0);
    check("R1 parent_irq in reset", parent_irq, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      case (VECS[k].op)
        OP_WR: do_wr(VECS[k].ix, VECS[k].data);
        OP_RD: begin
          do_rd(VECS[k].ix, got);
          check($sformatf("vector %0d R%0d read", k, VECS[k].req), got, VECS[k].exp);
        end
        default: begin
          do_irq(VECS[k].data);
          check($sformatf("vector %0d R%0d parent", k, VECS[k].req), parent_irq, VECS[k].exp);
        end
      endcase
    end

    // R11 read and write in the same cycle returns the old mask
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 10'd2; wdata = 32'h0000_0F00;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R11 read before write", rdata, 32'h8000_0000);
    do_rd(10'd2, got);
    check("R11 write then landed", got, 32'h8000_0F00);

    // R3 summary follows the input one clock later
    @(negedge clk); irq_in = 32'h0000_0100;
    @(posedge clk); #1;
    check("R3 one-cycle lag", parent_irq, 32'h8000_0000);

    // R1 reset mid-run clears all state
    @(negedge clk); irq_in = 32'hFFFF_FFFF; rst = 1'b1;
    @(negedge clk);
    check("R1 parent cleared", parent_irq, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 nothing enabled after reset", parent_irq, 32'h0);
    do_rd(10'd2, got);
    check("R1 mask cleared", got, 32'h0);
    do_rd(10'd8, got);
    check("R1 routing cleared", got, 32'h0);
    do_rd(10'd1, got);
    check("R2 raw after reset", got, 32'hFFFF_FFFF);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule